// File: doc/BRIEF.md
# Masked Quadword-to-Byte Narrowing Unit

This block narrows a vector of 64-bit integer lanes to one byte per lane and packs the bytes into the low end of a 128-bit destination. Each lane is narrowed by one of three rules, selected per operation: keep the low byte, clamp to the signed byte range, or clamp to the unsigned byte range. A vector-length code chooses how many lanes take part: 2, 4 or 8, which corresponds to a 128-, 256- or 512-bit source.

A per-lane write mask controls which result bytes are delivered. The operation can target a register or memory. For a register target, the unit builds the full 128-bit value: lanes that are masked off either keep the previous destination byte or become zero, and every byte above the active lane count is cleared. For a memory target, the unit produces 64 bits of store data with one byte enable per lane. Only the enabled bytes are to be written, so masked-off lanes keep their memory contents.

The unit is a single registered stage. An operation presented with `op_valid` in one cycle appears on the outputs, with `res_valid`, in the next cycle. Operand fetch, decode and the memory write itself belong to the surrounding pipeline.

Top module: `qw_narrow_unit`

## Requirements
- R1: Results are registered. `res_valid` is high exactly in the cycle after a cycle with `op_valid` high. When `res_valid` is low, including during reset, `reg_dst`, `st_data`, `st_be` and `illegal_op` are all zero.
- R2: `vec_len` encodes the lane count as 2'b00 = 2 lanes, 2'b01 = 4 lanes and 2'b10 = 8 lanes. Lane j is read from `src[64j+63:64j]`, and its result byte occupies bits [8j+7:8j] of `reg_dst` and `st_data`.
- R3: With `narrow_mode` = 2'b00 (truncate), the result byte is bits [7:0] of the lane.
- R4: With `narrow_mode` = 2'b01 (signed clamp), the lane is read as a signed 64-bit value. Values above 127 give 8'h7F, values below -128 give 8'h80, and all other values give their low byte.
- R5: With `narrow_mode` = 2'b10 (unsigned clamp), the lane is read as unsigned. Values above 255 give 8'hFF, and all other values give their low byte.
- R6: A result byte carries the narrowed value when `mask_on` is 0, or when `mask_on` is 1 and `lane_mask[j]` is 1.
- R7: For a register target (`to_mem` = 0), an active lane whose mask bit is 0 while `mask_on` is 1 does one of two things. It takes `prev_dst[8j+7:8j]` when `zero_fill` = 0, and 8'h00 when `zero_fill` = 1.
- R8: For a register target, every bit of `reg_dst` from bit 8×lanes up to bit 127 is zero. Also, `st_be` and `st_data` are zero.
- R9: For a memory target (`to_mem` = 1), `st_be[j]` is 1 exactly for active lanes selected under R6. `st_data` carries the narrowed byte in those lanes and zero elsewhere. `reg_dst` is zero, and `zero_fill` has no effect.
- R10: A mode code of 2'b11 or a length code of 2'b11 raises `illegal_op` alongside `res_valid`. In that case `reg_dst`, `st_data` and `st_be` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| narrow_mode | input | 2 | 00 truncate, 01 signed clamp, 10 unsigned clamp |
| vec_len | input | 2 | 00 two lanes, 01 four, 10 eight |
| mask_on | input | 1 | Apply `lane_mask` |
| zero_fill | input | 1 | Register target: masked-off bytes become zero instead of keeping old value |
| to_mem | input | 1 | Target is memory (byte-enabled store) |
| lane_mask | input | 8 | Per-lane write mask |
| src | input | 512 | Source lanes, lane j at [64j+63:64j] |
| prev_dst | input | 64 | Old low destination bytes used for merging |
| res_valid | output | 1 | Result present |
| illegal_op | output | 1 | Unused mode or length code |
| reg_dst | output | 128 | Register-target result |
| st_data | output | 64 | Memory-target store data |
| st_be | output | 8 | Memory-target byte enables |

## Verification
The assertions assume that `rst_n` is applied before the first operation. They also assume that the control inputs are valid 0/1 levels whenever `op_valid` is high. Under those assumptions, they check only the relations between the registered outputs and the registered control state. The stimulus changes inputs only on the falling edge, so each operation is held stable across the capturing edge. It also keeps `op_valid` low through reset. Illegal codes are sent on purpose, but only as complete operations, so R10 is exercised without breaking those assumptions.

// File: rtl/nrw_pkg.sv
package nrw_pkg;

    typedef enum logic [1:0] {
        NRW_TRUNC   = 2'b00,
        NRW_SCLAMP  = 2'b01,
        NRW_UCLAMP  = 2'b10,
        NRW_BADMODE = 2'b11
    } nrw_mode_e;

    typedef enum logic [1:0] {
        NRW_LEN2   = 2'b00,
        NRW_LEN4   = 2'b01,
        NRW_LEN8   = 2'b10,
        NRW_BADLEN = 2'b11
    } nrw_len_e;

    // Active-lane vector for a length code (bit j set when lane j participates).
    function automatic logic [7:0] nrw_active(input logic [1:0] len);
        logic [7:0] act;
        act = 8'h00;
        for (int j = 0; j < 8; j++) begin
            if (len != NRW_BADLEN && j < (2 << len)) act[j] = 1'b1;
        end
        return act;
    endfunction

endpackage

// File: rtl/nrw_lane_conv.sv
module nrw_lane_conv #(
    parameter int SRC_W = 64,
    parameter int OUT_W = 8
) (
    input  logic [1:0]       mode_i,
    input  logic [SRC_W-1:0] lane_i,
    output logic [OUT_W-1:0] byte_o
);
    import nrw_pkg::*;

    localparam int HI_W = SRC_W - OUT_W;

    logic signed_fits;
    logic unsigned_fits;
    logic [OUT_W-1:0] s_max, s_min, u_max;

    // Signed value fits when bits [SRC_W-1:OUT_W-1] are all equal.
    assign signed_fits   = (lane_i[SRC_W-1:OUT_W-1] == '0) || (lane_i[SRC_W-1:OUT_W-1] == '1);
    assign unsigned_fits = (lane_i[SRC_W-1:OUT_W] == {HI_W{1'b0}});
    assign s_max         = {1'b0, {(OUT_W-1){1'b1}}};
    assign s_min         = {1'b1, {(OUT_W-1){1'b0}}};
    assign u_max         = {OUT_W{1'b1}};

    always_comb begin
        unique case (nrw_mode_e'(mode_i))
            NRW_SCLAMP: begin
                if (signed_fits)          byte_o = lane_i[OUT_W-1:0];
                else if (lane_i[SRC_W-1]) byte_o = s_min;
                else                      byte_o = s_max;
            end
            NRW_UCLAMP: byte_o = unsigned_fits ? lane_i[OUT_W-1:0] : u_max;
            default:    byte_o = lane_i[OUT_W-1:0];
        endcase
    end

endmodule

// File: rtl/nrw_byte_select.sv
module nrw_byte_select #(
    parameter int LANES  = 8,
    parameter int BYTE_W = 8,
    parameter int DST_W  = 128
) (
    input  logic [LANES*BYTE_W-1:0] conv_i,
    input  logic [LANES-1:0]        active_i,
    input  logic [LANES-1:0]        kmask_i,
    input  logic                    mask_on_i,
    input  logic                    zero_fill_i,
    input  logic                    to_mem_i,
    input  logic [LANES*BYTE_W-1:0] prev_i,
    output logic [DST_W-1:0]        reg_o,
    output logic [LANES*BYTE_W-1:0] st_data_o,
    output logic [LANES-1:0]        st_be_o
);
    localparam int LOW_W = LANES * BYTE_W;

    logic [LOW_W-1:0] reg_low;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic take;
        assign take = active_i[j] && (!mask_on_i || kmask_i[j]);

        always_comb begin
            reg_low[j*BYTE_W +: BYTE_W]   = '0;
            st_data_o[j*BYTE_W +: BYTE_W] = '0;
            st_be_o[j]                    = 1'b0;
            if (to_mem_i) begin
                if (take) begin
                    st_data_o[j*BYTE_W +: BYTE_W] = conv_i[j*BYTE_W +: BYTE_W];
                    st_be_o[j]                    = 1'b1;
                end
            end else if (active_i[j]) begin
                if (take)              reg_low[j*BYTE_W +: BYTE_W] = conv_i[j*BYTE_W +: BYTE_W];
                else if (!zero_fill_i) reg_low[j*BYTE_W +: BYTE_W] = prev_i[j*BYTE_W +: BYTE_W];
            end
        end
    end

    if (DST_W > LOW_W) begin : g_pad
        assign reg_o = {{(DST_W-LOW_W){1'b0}}, reg_low};
    end else begin : g_nopad
        assign reg_o = reg_low[DST_W-1:0];
    end

endmodule

// File: rtl/qw_narrow_unit.sv
module qw_narrow_unit #(
    parameter int LANES  = 8,
    parameter int LANE_W = 64,
    parameter int BYTE_W = 8,
    parameter int DST_W  = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_valid,
    input  logic [1:0]                 narrow_mode,
    input  logic [1:0]                 vec_len,
    input  logic                       mask_on,
    input  logic                       zero_fill,
    input  logic                       to_mem,
    input  logic [LANES-1:0]           lane_mask,
    input  logic [LANES*LANE_W-1:0]    src,
    input  logic [LANES*BYTE_W-1:0]    prev_dst,
    output logic                       res_valid,
    output logic                       illegal_op,
    output logic [DST_W-1:0]           reg_dst,
    output logic [LANES*BYTE_W-1:0]    st_data,
    output logic [LANES-1:0]           st_be
);
    import nrw_pkg::*;

    localparam int LOW_W = LANES * BYTE_W;

    logic                 legal;
    logic [LANES-1:0]     active;
    logic [LOW_W-1:0]     conv;
    logic [DST_W-1:0]     reg_nxt;
    logic [LOW_W-1:0]     st_data_nxt;
    logic [LANES-1:0]     st_be_nxt;
    logic                 to_mem_q;
    logic [1:0]           len_q;

    assign legal = (narrow_mode != NRW_BADMODE) && (vec_len != NRW_BADLEN);

    for (genvar j = 0; j < LANES; j++) begin : g_act
        assign active[j] = (vec_len != NRW_BADLEN) && (j < (2 << vec_len));
    end

    for (genvar j = 0; j < LANES; j++) begin : g_conv
        nrw_lane_conv #(.SRC_W(LANE_W), .OUT_W(BYTE_W)) u_conv (
            .mode_i (narrow_mode),
            .lane_i (src[j*LANE_W +: LANE_W]),
            .byte_o (conv[j*BYTE_W +: BYTE_W])
        );
    end

    nrw_byte_select #(.LANES(LANES), .BYTE_W(BYTE_W), .DST_W(DST_W)) u_sel (
        .conv_i      (conv),
        .active_i    (active),
        .kmask_i     (lane_mask),
        .mask_on_i   (mask_on),
        .zero_fill_i (zero_fill),
        .to_mem_i    (to_mem),
        .prev_i      (prev_dst),
        .reg_o       (reg_nxt),
        .st_data_o   (st_data_nxt),
        .st_be_o     (st_be_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            illegal_op <= 1'b0;
            reg_dst    <= '0;
            st_data    <= '0;
            st_be      <= '0;
            to_mem_q   <= 1'b0;
            len_q      <= 2'b00;
        end else begin
            res_valid  <= op_valid;
            illegal_op <= op_valid && !legal;
            to_mem_q   <= op_valid && to_mem;
            len_q      <= vec_len;
            if (op_valid && legal) begin
                reg_dst <= reg_nxt;
                st_data <= st_data_nxt;
                st_be   <= st_be_nxt;
            end else begin
                reg_dst <= '0;
                st_data <= '0;
                st_be   <= '0;
            end
        end
    end

    // R1: one-cycle latency of the valid flag
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    // R1: quiet outputs when no result
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (reg_dst == '0 && st_be == '0 && st_data == '0 && !illegal_op));
    // R8: no store enables for a register target
    a_r8_reg_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !to_mem_q) |-> (st_be == '0 && st_data == '0));
    // R8: bits above the widest lane count stay clear
    a_r8_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        reg_dst[DST_W-1:LOW_W] == '0);
    // R9: enables only within active lanes, and no register result
    a_r9_be_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && to_mem_q) |-> ((st_be & ~nrw_active(len_q)) == '0 && reg_dst == '0));
    // R10: illegal operation produces no data
    a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (res_valid && reg_dst == '0 && st_be == '0 && st_data == '0));

endmodule

// File: tb/qw_narrow_unit_bench.sv
module qw_narrow_unit_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [1:0]   narrow_mode = 2'b00;
    logic [1:0]   vec_len = 2'b00;
    logic         mask_on = 1'b0;
    logic         zero_fill = 1'b0;
    logic         to_mem = 1'b0;
    logic [7:0]   lane_mask = 8'h00;
    logic [511:0] src = '0;
    logic [63:0]  prev_dst = '0;
    logic         res_valid, illegal_op;
    logic [127:0] reg_dst;
    logic [63:0]  st_data;
    logic [7:0]   st_be;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [127:0] q_d[$];
    logic [63:0]  q_sd[$];
    logic [7:0]   q_be[$];
    logic         q_il[$];
    logic         q_v[$];
    string        q_tag[$];

    always #5 clk = ~clk;

    qw_narrow_unit u_qw_narrow_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .narrow_mode(narrow_mode),
        .vec_len(vec_len), .mask_on(mask_on), .zero_fill(zero_fill), .to_mem(to_mem),
        .lane_mask(lane_mask), .src(src), .prev_dst(prev_dst),
        .res_valid(res_valid), .illegal_op(illegal_op), .reg_dst(reg_dst),
        .st_data(st_data), .st_be(st_be)
    );

    function automatic logic [63:0] bval(input int i);
        case (i % 9)
            0: return 64'd127;
            1: return 64'd128;
            2: return 64'hFFFF_FFFF_FFFF_FF80;
            3: return 64'hFFFF_FFFF_FFFF_FF7F;
            4: return 64'd255;
            5: return 64'd256;
            6: return 64'd0;
            7: return 64'h8000_0000_0000_0000;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [7:0] ref_conv(input logic [1:0] m, input logic [63:0] v);
        longint sv;
        sv = longint'(v);
        if (m == 2'b01) begin
            if (sv > 127) return 8'h7F;
            if (sv < -128) return 8'h80;
            return v[7:0];
        end
        if (m == 2'b10) return (v > 64'd255) ? 8'hFF : v[7:0];
        return v[7:0];
    endfunction

    task automatic compare();
        logic [127:0] ed; logic [63:0] esd; logic [7:0] ebe; logic eil, ev; string t;
        ed = q_d.pop_front(); esd = q_sd.pop_front(); ebe = q_be.pop_front();
        eil = q_il.pop_front(); ev = q_v.pop_front(); t = q_tag.pop_front();
        total++;
        if (res_valid !== ev || illegal_op !== eil || reg_dst !== ed ||
            st_data !== esd || st_be !== ebe) begin
            fails++;
            $display("FAIL %s: got v=%b il=%b d=%h sd=%h be=%h exp v=%b il=%b d=%h sd=%h be=%h",
                     t, res_valid, illegal_op, reg_dst, st_data, st_be, ev, eil, ed, esd, ebe);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] m, input logic [1:0] vl,
                        input logic me, input logic zf, input logic md,
                        input logic [7:0] k, input logic [511:0] s,
                        input logic [63:0] od, input string tag);
        logic [127:0] ed; logic [63:0] esd; logic [7:0] ebe; logic eil;
        int n;
        @(negedge clk);
        if (q_v.size() > 0) compare();
        op_valid = v; narrow_mode = m; vec_len = vl; mask_on = me; zero_fill = zf;
        to_mem = md; lane_mask = k; src = s; prev_dst = od;
        ed = '0; esd = '0; ebe = '0; eil = 1'b0;
        if (v && (m == 2'b11 || vl == 2'b11)) eil = 1'b1;
        else if (v) begin
            n = 2 << vl;
            for (int j = 0; j < n; j++) begin
                logic [7:0] c; logic sel;
                c = ref_conv(m, s[j*64 +: 64]);
                sel = !me || k[j];
                if (md) begin
                    if (sel) begin esd[j*8 +: 8] = c; ebe[j] = 1'b1; end
                end else if (sel) ed[j*8 +: 8] = c;
                else if (!zf) ed[j*8 +: 8] = od[j*8 +: 8];
            end
        end
        q_d.push_back(ed); q_sd.push_back(esd); q_be.push_back(ebe);
        q_il.push_back(eil); q_v.push_back(v); q_tag.push_back(tag);
    endtask

    function automatic logic [511:0] rand_src(input int seed);
        logic [511:0] s;
        for (int j = 0; j < 8; j++) begin
            if ($urandom % 2 == 0) s[j*64 +: 64] = bval(seed + j);
            else s[j*64 +: 64] = {$urandom, $urandom};
        end
        return s;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got no end, exp end of stimulus");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [511:0] s;
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            total++;
            if (res_valid !== 1'b0 || reg_dst !== '0 || st_be !== '0 || st_data !== '0 || illegal_op !== 1'b0) begin
                fails++;
                $display("FAIL R1 reset: got v=%b d=%h be=%h exp all zero", res_valid, reg_dst, st_be);
            end
        end
        rst_n = 1'b1;

        // R3 R4 R5 R2: boundary values, all modes and lengths, no mask
        for (int m = 0; m < 3; m++) begin
            for (int vl = 0; vl < 3; vl++) begin
                for (int r = 0; r < 9; r++) begin
                    for (int j = 0; j < 8; j++) s[j*64 +: 64] = bval(r + j);
                    step(1'b1, 2'(m), 2'(vl), 1'b0, 1'b0, 1'b0, 8'h00, s, 64'hA5A5_5A5A_C3C3_3C3C,
                         (m == 0) ? "R3 truncate" : (m == 1) ? "R4 signed clamp" : "R5 unsigned clamp");
                end
            end
        end
        // R6 R7: random masks, merge then zero fill
        for (int i = 0; i < 120; i++) begin
            step(1'b1, 2'($urandom % 3), 2'($urandom % 3), 1'b1, 1'b0, 1'b0, 8'($urandom),
                 rand_src(i), {$urandom, $urandom}, "R7 merge");
            step(1'b1, 2'($urandom % 3), 2'($urandom % 3), 1'b1, 1'b1, 1'b0, 8'($urandom),
                 rand_src(i + 3), {$urandom, $urandom}, "R7 zero fill");
            step(1'b1, 2'($urandom % 3), 2'($urandom % 3), 1'b0, 1'($urandom), 1'b0, 8'($urandom),
                 rand_src(i + 5), {$urandom, $urandom}, "R6 mask off");
        end
        // R8: 2-lane register result with full old value, upper bytes must clear
        step(1'b1, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 8'h00, '1, 64'hFFFF_FFFF_FFFF_FFFF, "R8 upper clear");
        // R9: memory target, random masks, zero_fill toggled
        for (int i = 0; i < 100; i++) begin
            step(1'b1, 2'($urandom % 3), 2'($urandom % 3), 1'($urandom), 1'($urandom), 1'b1,
                 8'($urandom), rand_src(i + 7), {$urandom, $urandom}, "R9 store");
        end
        // R10: illegal codes
        step(1'b1, 2'b11, 2'b10, 1'b0, 1'b0, 1'b0, 8'hFF, '1, '1, "R10 bad mode");
        step(1'b1, 2'b00, 2'b11, 1'b0, 1'b0, 1'b1, 8'hFF, '1, '1, "R10 bad length");
        step(1'b1, 2'b11, 2'b11, 1'b1, 1'b1, 1'b0, 8'hFF, '1, '1, "R10 both bad");
        // R1: idle cycles between operations
        step(1'b0, 2'b01, 2'b10, 1'b0, 1'b0, 1'b1, 8'hFF, '1, '1, "R1 idle");
        step(1'b1, 2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 8'hFF, rand_src(1), '1, "R1 after idle");
        step(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 8'h00, '0, '0, "R1 idle");
        step(1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 8'h00, '0, '0, "R1 idle");
        @(negedge clk);
        while (q_v.size() > 0) compare();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule